// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block resolves a destination address to a next-hop value with longest-prefix-match semantics. It does this with two directly indexed tables, so it never has to compare against stored prefixes. The address is cut into a high part and a low part. The high part selects one entry of the first-level table. That entry either holds the final next hop or points to a second-level block, and the low part of the address then selects a next hop inside that block. Management logic is expected to expand every prefix into table entries beforehand: a short prefix fills a run of first-level entries, and a long prefix fills part of a second-level block.

The lookup is a two-stage pipeline. Each stage makes one table access. A new address can be issued on every clock, and each result appears exactly two cycles after its address, in issue order. A single write port loads entries into either table. A zero next hop marks an absent route, and the block reports it as a miss.

Top module: `lpm_lookup`

## Requirements
- R1: After reset, `res_valid` is 0 and every entry of both tables is zero, so any lookup issued before the first write returns a miss.
- R2: A lookup is accepted in every cycle where `lk_valid` is 1, including back-to-back cycles. Its result is shown on the outputs with `res_valid`=1 exactly two cycles later. Results keep issue order. `res_valid` is 0 in every cycle that does not correspond to an issued lookup.
- R3: The first-level index is `lk_addr[HI_W+LO_W-1:LO_W]` and the low index is `lk_addr[LO_W-1:0]`.
- R4: A first-level entry is NH_W+1 bits wide. Bit NH_W is the pointer flag. When that flag is 0, bits NH_W-1:0 are returned unchanged as the next hop.
- R5: When the pointer flag is 1, bits BLK_W-1:0 of the entry name a block. The lookup then returns second-level entry number block*2^LO_W + low index, which is NH_W bits wide.
- R6: A resolved next hop of zero gives `res_miss`=1 and `res_nh`=0. Any other value gives `res_miss`=0. A first-level entry equal to {1, zero payload} points to block 0 and is not a miss in itself.
- R7: When `wr_en` is 1, `wr_tbl`=0 writes `wr_data` into first-level entry `wr_idx[HI_W-1:0]`. `wr_tbl`=1 writes `wr_data[NH_W-1:0]` into second-level entry `wr_idx[L2A_W-1:0]`.
- R8: A first-level write is not seen by a lookup issued in the same cycle, but it is seen by lookups issued later. A second-level entry is read in the cycle after issue. A write there in the issue cycle is therefore seen, and a write in the following cycle is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Issue a lookup this cycle |
| lk_addr | input | HI_W+LO_W | Destination address to resolve |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | Table select: 0 first level, 1 second level |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_data | input | NH_W+1 | Entry value for the write |
| res_valid | output | 1 | Result present this cycle |
| res_miss | output | 1 | No route for this result |
| res_nh | output | NH_W | Resolved next hop (zero on a miss) |

## Verification
A corrupted first-level entry or a wrong pointer decode shows up at the ports two cycles after the affected address is issued, as a wrong next hop or a false miss. Lookups that avoid that entry keep returning correct results. A fault in how the valid bit moves along the pipeline shows up in the very next cycle after the missing or extra stage transfer, as a result that arrives a cycle early, arrives late or never arrives. A write that lands at the wrong moment relative to a read only becomes visible when a lookup reaches the written entry in its boundary cycle. For that reason the bench drives writes and lookups to the same entry together, in the same cycle and in adjacent cycles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic {
    TBL_FIRST  = 1'b0,
    TBL_SECOND = 1'b1
  } lpm_tbl_e;
endpackage

// File: rtl/lpm_table.sv
module lpm_table #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // The read samples the array before this edge's write lands (R8 ordering).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  // R8: the read register only changes when a read is requested
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lpm_resolve.sv
module lpm_resolve #(
  parameter int NH_W  = 8,
  parameter int LO_W  = 4,
  parameter int BLK_W = 3,
  localparam int L2A_W = BLK_W + LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [NH_W:0]    s1_entry,
  input  logic [LO_W-1:0]  s1_lo,
  output logic             l2_rd_en,
  output logic [L2A_W-1:0] l2_rd_addr,
  input  logic [NH_W-1:0]  l2_rd_data,
  output logic             res_valid,
  output logic             res_miss,
  output logic [NH_W-1:0]  res_nh
);
  function automatic logic entry_is_ptr(input logic [NH_W:0] e);
    return e[NH_W];
  endfunction

  function automatic logic [NH_W-1:0] entry_payload(input logic [NH_W:0] e);
    return e[NH_W-1:0];
  endfunction

  function automatic logic [L2A_W-1:0] block_slot(input logic [NH_W-1:0] pay,
                                                  input logic [LO_W-1:0] lo);
    return {pay[BLK_W-1:0], lo};
  endfunction

  logic            s1_ptr;
  logic [NH_W-1:0] s1_pay;
  logic            s2_valid, s2_ptr;
  logic [NH_W-1:0] s2_direct;
  logic [NH_W-1:0] hop;
  logic            hop_none;

  assign s1_ptr     = entry_is_ptr(s1_entry);
  assign s1_pay     = entry_payload(s1_entry);
  assign l2_rd_en   = s1_valid && s1_ptr;
  assign l2_rd_addr = block_slot(s1_pay, s1_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid  <= 1'b0;
      s2_ptr    <= 1'b0;
      s2_direct <= '0;
    end else begin
      s2_valid  <= s1_valid;
      s2_ptr    <= s1_ptr;
      s2_direct <= s1_pay;
    end
  end

  assign hop       = s2_ptr ? l2_rd_data : s2_direct;
  assign hop_none  = (hop == '0);
  assign res_valid = s2_valid;
  assign res_miss  = s2_valid && hop_none;
  assign res_nh    = s2_valid ? hop : '0;

  // R2: every first-stage item reaches the output one cycle later
  assert_stage_fwd_R2: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> res_valid);
  // R2: no result without a first-stage item
  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !res_valid);
  // R4: a direct entry comes out unchanged
  assert_direct_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_entry[NH_W]) |=> (res_nh == $past(s1_entry[NH_W-1:0])));
  // R6: a miss is only ever flagged on a valid result, with a zero hop
  assert_miss_clean_R6: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (res_valid && res_nh == '0));
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup #(
  parameter int HI_W = 8,
  parameter int LO_W = 4,
  parameter int NH_W = 8,
  parameter int NBLK = 8,
  localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int L2A_W  = BLK_W + LO_W,
  localparam int ADDR_W = HI_W + LO_W,
  localparam int IDX_W  = (HI_W > L2A_W) ? HI_W : L2A_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              wr_en,
  input  logic              wr_tbl,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NH_W:0]     wr_data,
  output logic              res_valid,
  output logic              res_miss,
  output logic [NH_W-1:0]   res_nh
);
  import lpm_pkg::*;

  logic [HI_W-1:0]  lk_hi;
  logic [LO_W-1:0]  lk_lo;
  logic             l1_we, l2_we;
  logic             s1_valid;
  logic [LO_W-1:0]  s1_lo;
  logic [NH_W:0]    s1_entry;
  logic             l2_rd_en;
  logic [L2A_W-1:0] l2_rd_addr;
  logic [NH_W-1:0]  l2_rd_data;

  assign lk_hi = lk_addr[ADDR_W-1:LO_W];
  assign lk_lo = lk_addr[LO_W-1:0];
  assign l1_we = wr_en && (lpm_tbl_e'(wr_tbl) == TBL_FIRST);
  assign l2_we = wr_en && (lpm_tbl_e'(wr_tbl) == TBL_SECOND);

  lpm_table #(.AW(HI_W), .DW(NH_W + 1)) u_first (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (lk_valid),
    .rd_addr (lk_hi),
    .rd_data (s1_entry),
    .wr_en   (l1_we),
    .wr_addr (wr_idx[HI_W-1:0]),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_lo    <= '0;
    end else begin
      s1_valid <= lk_valid;
      s1_lo    <= lk_lo;
    end
  end

  lpm_resolve #(.NH_W(NH_W), .LO_W(LO_W), .BLK_W(BLK_W)) u_resolve (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (s1_valid),
    .s1_entry   (s1_entry),
    .s1_lo      (s1_lo),
    .l2_rd_en   (l2_rd_en),
    .l2_rd_addr (l2_rd_addr),
    .l2_rd_data (l2_rd_data),
    .res_valid  (res_valid),
    .res_miss   (res_miss),
    .res_nh     (res_nh)
  );

  lpm_table #(.AW(L2A_W), .DW(NH_W)) u_second (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (l2_rd_en),
    .rd_addr (l2_rd_addr),
    .rd_data (l2_rd_data),
    .wr_en   (l2_we),
    .wr_addr (wr_idx[L2A_W-1:0]),
    .wr_data (wr_data[NH_W-1:0])
  );

  // R2: an issued lookup enters the first stage on the next edge
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> s1_valid);
  // R7: the two table write strobes never fire together
  assert_one_table_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l1_we, l2_we}));
endmodule

// File: tb/lpm_lookup_tb.sv
`timescale 1ns/1ps
module lpm_lookup_tb;
  localparam int HI_W = 8, LO_W = 4, NH_W = 8, NBLK = 8;
  localparam int BLK_W = 3, L2A_W = BLK_W + LO_W, IDX_W = 8;
  localparam int ADDR_W = HI_W + LO_W;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 1'b0, wr_en = 1'b0, wr_tbl = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [NH_W:0]     wr_data = '0;
  logic res_valid, res_miss;
  logic [NH_W-1:0] res_nh;

  always #4 clk = ~clk;

  lpm_lookup #(.HI_W(HI_W), .LO_W(LO_W), .NH_W(NH_W), .NBLK(NBLK)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_idx(wr_idx), .wr_data(wr_data),
    .res_valid(res_valid), .res_miss(res_miss), .res_nh(res_nh)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [NH_W:0]   m_first  [1 << HI_W];
  logic [NH_W-1:0] m_second [1 << L2A_W];

  // pipeline expectation: first stage, then what the outputs show
  logic            p_valid = 1'b0;
  logic [NH_W:0]   p_entry = '0;
  logic [LO_W-1:0] p_lo = '0;
  logic            e_valid = 1'b0;
  logic [NH_W-1:0] e_hop = '0;
  string           e_tag = "R1";
  string           p_tag = "R2";

  function automatic logic [ADDR_W-1:0] mk_addr(int hi, int lo);
    return ADDR_W'((hi << LO_W) | lo);
  endfunction

  function automatic int second_slot(logic [NH_W:0] e, logic [LO_W-1:0] lo);
    return (int'(e[BLK_W-1:0]) * (1 << LO_W)) + int'(lo);
  endfunction

  task automatic check_outputs();
    n_run++;
    if (res_valid !== e_valid) begin
      n_fail++;
      $display("FAIL %s: res_valid=%0b expected %0b", e_tag, res_valid, e_valid);
    end else if (e_valid) begin
      n_run++;
      if (res_nh !== e_hop || res_miss !== (e_hop == '0)) begin
        n_fail++;
        $display("FAIL %s: nh=%0h miss=%0b expected nh=%0h miss=%0b",
                 e_tag, res_nh, res_miss, e_hop, (e_hop == '0));
      end
    end
  endtask

  // one clock: check last outputs, drive, advance the reference
  task automatic step(bit v, logic [ADDR_W-1:0] a, bit we, bit tbl,
                      int idx, int data, string tag);
    @(negedge clk);
    check_outputs();
    lk_valid = v; lk_addr = a;
    wr_en = we; wr_tbl = tbl;
    wr_idx = IDX_W'(idx); wr_data = (NH_W+1)'(data);
    // R5: second-level read uses the table as it stands before this edge
    e_valid = p_valid;
    e_tag   = p_tag;
    if (p_valid)
      e_hop = p_entry[NH_W] ? m_second[second_slot(p_entry, p_lo)] : p_entry[NH_W-1:0];
    // R3: index split, R8: first-level read before this edge's write
    p_valid = v;
    p_tag   = tag;
    if (v) begin
      p_entry = m_first[a[ADDR_W-1:LO_W]];
      p_lo    = a[LO_W-1:0];
    end
    if (we) begin
      if (!tbl) m_first[idx[HI_W-1:0]] = (NH_W+1)'(data);
      else      m_second[idx[L2A_W-1:0]] = NH_W'(data);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << HI_W); i++) m_first[i] = '0;
    for (int i = 0; i < (1 << L2A_W); i++) m_second[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, then lookups into empty tables miss
    idle(1);
    step(1, mk_addr(0, 0), 0, 0, 0, 0, "R1");
    step(1, mk_addr(255, 15), 0, 0, 0, 0, "R1");
    step(1, mk_addr(77, 3), 0, 0, 0, 0, "R1");
    idle(2);

    // R4 / R7: direct first-level result, R3: any low part gives it
    step(0, '0, 1, 0, 5, 9'h03C, "R7");
    step(1, mk_addr(5, 0), 0, 0, 0, 0, "R4");
    step(1, mk_addr(5, 15), 0, 0, 0, 0, "R3");
    step(1, mk_addr(4, 15), 0, 0, 0, 0, "R3");
    idle(2);

    // R5: pointer to block 2, R6: empty slot in that block misses
    step(0, '0, 1, 0, 9, 9'h102, "R7");
    step(0, '0, 1, 1, 2*16+7, 8'h55, "R7");
    step(1, mk_addr(9, 7), 0, 0, 0, 0, "R5");
    step(1, mk_addr(9, 8), 0, 0, 0, 0, "R6");
    // R6: pointer with zero payload selects block 0, not a miss by itself
    step(0, '0, 1, 0, 10, 9'h100, "R7");
    step(0, '0, 1, 1, 3, 8'hA1, "R7");
    step(1, mk_addr(10, 3), 0, 0, 0, 0, "R6");
    idle(2);

    // R8: first-level write in the same cycle as lookup is not seen
    step(1, mk_addr(5, 1), 1, 0, 5, 9'h077, "R8");
    step(1, mk_addr(5, 1), 0, 0, 0, 0, "R8");
    // R8: second-level write in issue cycle seen, in the next cycle not
    step(1, mk_addr(9, 3), 1, 1, 2*16+3, 8'h11, "R8");
    step(1, mk_addr(9, 4), 0, 0, 0, 0, "R8");
    step(0, '0, 1, 1, 2*16+4, 8'h22, "R8");
    step(1, mk_addr(9, 4), 0, 0, 0, 0, "R8");
    idle(2);

    // R2: back-to-back stream with valid gaps, mixed random writes
    for (int i = 0; i < 4000; i++) begin
      bit v, we, tbl;
      int hi, lo, idx, data;
      v   = ($urandom % 4) != 0;
      hi  = $urandom % 16;
      lo  = $urandom % 16;
      we  = ($urandom % 5) == 0;
      tbl = $urandom % 2;
      if (!tbl) begin
        idx = $urandom % 16;
        case ($urandom % 3)
          0: data = 0;
          1: data = $urandom % 256;
          default: data = 256 | ($urandom % NBLK);
        endcase
      end else begin
        idx  = ($urandom % NBLK) * 16 + ($urandom % 16);
        data = (($urandom % 4) == 0) ? 0 : ($urandom % 256);
      end
      step(v, mk_addr(hi, lo), we, tbl, idx, data, "R2");
    end
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule